// File: doc/BRIEF.md
# Priority Pin Crossbar Assigner

This block decides which on-chip digital peripheral signal drives each of 32 physical I/O pins, arranged as four ports of eight pins. Each enabled peripheral signal takes the lowest-numbered free pin, in a fixed priority order. A per-pin skip mask removes pins from consideration. The transmit and receive lines of the first serial port are tied to fixed pins. Any pin that no signal claims is left to general-purpose I/O.

The assignment is computed combinationally from the enable inputs, the SPI wire-mode input and the skip mask, then captured in a register once per clock. The registered assignment appears as a 5-bit signal code per pin. A per-pin output multiplexer uses that code to route a peripheral's output value and output enable, or the GPIO value and enable, onto the pin. When the pins run out, any signal that could not be placed raises its own "not pinned" flag.

Top module: `pin_xbar`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every pin code becomes 0 and `not_pinned` becomes all zero. After reset, `pin_code` and `not_pinned` reflect the inputs sampled at the previous rising edge.
- R2: Pin p's code sits in `pin_code[5p+4:5p]`, with pin p = 8*port + bit. The codes are: 0 GPIO, 1 serial0 TX, 2 serial0 RX, 3 SPI clock, 4 MISO, 5 MOSI, 6 slave select, 7 two-wire data, 8 two-wire clock, 9 cmp0 sync, 10 cmp0 async, 11 cmp1 sync, 12 cmp1 async, 13 system clock, 14..18 capture/compare 0..4, 19 external counter input, 20 timer 0, 21 timer 1, 22 serial1 TX, 23 serial1 RX. Enabled signals from code 3 upward are placed in ascending code order onto free pins in ascending pin order.
- R3: A pin whose `skip_mask` bit is set never receives a packed signal (codes 3..23). Packing continues at the next higher free pin.
- R4: When `en_uart0` is 1, pin 4 gets code 1 and pin 5 gets code 2, even if those pins are skipped, and both are withheld from packing. When `en_uart0` is 0, pins 4 and 5 are ordinary free pins.
- R5: `en_twi` requests both codes 7 and 8. `en_uart1` requests both codes 22 and 23.
- R6: `en_spi` requests codes 3, 4 and 5. Code 6 is requested only when `spi_4wire` is also 1.
- R7: `cap_cnt` = n requests capture/compare outputs 0..n-1 (codes 14..13+n). Values 6 and 7 act as 5.
- R8: Every free pin that no enabled signal claims gets code 0. A skipped pin not held by serial0 also gets code 0.
- R9: `not_pinned[c-1]` is 1 exactly when signal code c was requested but no free pin remained for it. Bits 0 and 1 are never set.
- R10: A pin with code 0 drives `gpio_out[p]` and `gpio_oe[p]`. A pin with code c drives `periph_out[c-1]` and `periph_oe[c-1]`. This path is combinational from the registered code.
- R11: No nonzero code appears on more than one pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_uart0 | input | 1 | Serial port 0 enable (fixed pins) |
| en_spi | input | 1 | SPI enable |
| spi_4wire | input | 1 | 1 = 4-wire SPI (slave select pinned) |
| en_twi | input | 1 | Two-wire bus enable |
| en_cmp0 | input | 1 | Comparator 0 synchronous output enable |
| en_cmp0a | input | 1 | Comparator 0 asynchronous output enable |
| en_cmp1 | input | 1 | Comparator 1 synchronous output enable |
| en_cmp1a | input | 1 | Comparator 1 asynchronous output enable |
| en_sysclk | input | 1 | System clock output enable |
| cap_cnt | input | 3 | Number of capture/compare outputs (0..5, clamped) |
| en_eci | input | 1 | External counter input enable |
| en_t0 | input | 1 | Timer 0 input enable |
| en_t1 | input | 1 | Timer 1 input enable |
| en_uart1 | input | 1 | Serial port 1 enable |
| skip_mask | input | 32 | Per-pin skip bits, bit 8*port+pin |
| periph_out | input | 23 | Peripheral output value, bit c-1 for code c |
| periph_oe | input | 23 | Peripheral output enable, bit c-1 for code c |
| gpio_out | input | 32 | GPIO output value per pin |
| gpio_oe | input | 32 | GPIO output enable per pin |
| pin_code | output | 160 | Registered 5-bit signal code per pin |
| not_pinned | output | 23 | Per-signal placement failure, bit c-1 |
| pin_out | output | 32 | Value driven on each pin |
| pin_oe | output | 32 | Output enable of each pin |

## Verification
The hardest situation to reach is pin exhaustion, where some requested signals fit and the rest must raise their flags. Mid-priority flags are especially hard to cover, and so is the interplay with the fixed serial0 pins. The stimulus gets there by skipping all but two pins: two signals land on the remaining pins and the third is flagged. It also skips every pin while serial0 stays enabled, which shows that the fixed pins override the skip mask and that every packed SPI signal is flagged.

// File: rtl/pinx_pkg.sv
// Shared constants for the pin crossbar: signal count, code width and
// the code of each crossbar signal (code value = priority, lower first).
package pinx_pkg;
    localparam int NSIG   = 23;
    localparam int CODE_W = $clog2(NSIG + 1);
    localparam int CEX_N  = 5;

    localparam logic [CODE_W-1:0] C_GPIO   = 5'd0;
    localparam logic [CODE_W-1:0] C_U0TX   = 5'd1;
    localparam logic [CODE_W-1:0] C_U0RX   = 5'd2;
    localparam logic [CODE_W-1:0] C_SCK    = 5'd3;
    localparam logic [CODE_W-1:0] C_MISO   = 5'd4;
    localparam logic [CODE_W-1:0] C_MOSI   = 5'd5;
    localparam logic [CODE_W-1:0] C_NSS    = 5'd6;
    localparam logic [CODE_W-1:0] C_SDA    = 5'd7;
    localparam logic [CODE_W-1:0] C_SCL    = 5'd8;
    localparam logic [CODE_W-1:0] C_CP0    = 5'd9;
    localparam logic [CODE_W-1:0] C_CP0A   = 5'd10;
    localparam logic [CODE_W-1:0] C_CP1    = 5'd11;
    localparam logic [CODE_W-1:0] C_CP1A   = 5'd12;
    localparam logic [CODE_W-1:0] C_SYSCLK = 5'd13;
    localparam logic [CODE_W-1:0] C_CEX0   = 5'd14;
    localparam logic [CODE_W-1:0] C_ECI    = 5'd19;
    localparam logic [CODE_W-1:0] C_T0     = 5'd20;
    localparam logic [CODE_W-1:0] C_T1     = 5'd21;
    localparam logic [CODE_W-1:0] C_TX1    = 5'd22;
    localparam logic [CODE_W-1:0] C_RX1    = 5'd23;
endpackage

// File: rtl/pinx_request.sv
// Builds the request vector (bit c-1 for code c) from the enable inputs.
// Assumes serial0 is never packed, so bits 0 and 1 stay zero.
module pinx_request
    import pinx_pkg::*;
(
    input  logic            en_spi,
    input  logic            spi_4wire,
    input  logic            en_twi,
    input  logic            en_cmp0,
    input  logic            en_cmp0a,
    input  logic            en_cmp1,
    input  logic            en_cmp1a,
    input  logic            en_sysclk,
    input  logic [2:0]      cap_cnt,
    input  logic            en_eci,
    input  logic            en_t0,
    input  logic            en_t1,
    input  logic            en_uart1,
    output logic [NSIG-1:0] req
);
    // Translate each enable into the request bits of its signal group.
    always_comb begin
        req = '0;
        req[C_SCK-1]    = en_spi;
        req[C_MISO-1]   = en_spi;
        req[C_MOSI-1]   = en_spi;
        req[C_NSS-1]    = en_spi & spi_4wire;
        req[C_SDA-1]    = en_twi;
        req[C_SCL-1]    = en_twi;
        req[C_CP0-1]    = en_cmp0;
        req[C_CP0A-1]   = en_cmp0a;
        req[C_CP1-1]    = en_cmp1;
        req[C_CP1A-1]   = en_cmp1a;
        req[C_SYSCLK-1] = en_sysclk;
        for (int i = 0; i < CEX_N; i++)
            req[int'(C_CEX0) - 1 + i] = (int'(cap_cnt) > i);
        req[C_ECI-1]    = en_eci;
        req[C_T0-1]     = en_t0;
        req[C_T1-1]     = en_t1;
        req[C_TX1-1]    = en_uart1;
        req[C_RX1-1]    = en_uart1;
    end
endmodule

// File: rtl/pinx_pack.sv
// Priority packer: the k-th requested signal (ascending code) goes to the
// k-th available pin (ascending index). Signals beyond the available pin
// count are flagged unplaced. Purely combinational.
module pinx_pack
    import pinx_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic [NSIG-1:0]        req,
    input  logic [NPIN-1:0]        avail,
    output logic [NPIN*CODE_W-1:0] code,
    output logic [NSIG-1:0]        unplaced
);
    logic [CODE_W-1:0] order [NSIG];
    int nav;
    int nreq;
    int slot;

    // Rank requested signals into an ordered list and flag the overflow.
    always_comb begin
        nav      = $countones(avail);
        nreq     = 0;
        unplaced = '0;
        for (int s = 0; s < NSIG; s++) order[s] = C_GPIO;
        for (int s = 0; s < NSIG; s++) begin
            if (req[s]) begin
                if (nreq < nav) order[nreq] = CODE_W'(s + 1);
                else            unplaced[s] = 1'b1;
                nreq = nreq + 1;
            end
        end
    end

    // Walk the available pins and hand out the ordered list.
    always_comb begin
        slot = 0;
        code = '0;
        for (int p = 0; p < NPIN; p++) begin
            if (avail[p]) begin
                if (slot < NSIG) code[p*CODE_W +: CODE_W] = order[slot];
                slot = slot + 1;
            end
        end
    end
endmodule

// File: rtl/pinx_pinmux.sv
// Output multiplexer of one pin: code 0 selects the GPIO value and enable,
// code c selects peripheral signal c-1. Assumes codes above NSIG never occur.
module pinx_pinmux
    import pinx_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [NSIG-1:0]   periph_out,
    input  logic [NSIG-1:0]   periph_oe,
    input  logic              gpio_out,
    input  logic              gpio_oe,
    output logic              pin_out,
    output logic              pin_oe
);
    logic [CODE_W-1:0] idx;

    // Pick the source of the pin's value and direction.
    always_comb begin
        idx     = code - 1'b1;
        pin_out = gpio_out;
        pin_oe  = gpio_oe;
        if (code != C_GPIO && int'(code) <= NSIG) begin
            pin_out = periph_out[idx];
            pin_oe  = periph_oe[idx];
        end
    end
endmodule

// File: rtl/pin_xbar.sv
// Top of the priority pin crossbar. Computes availability (skip mask and
// fixed serial0 pins), packs requested signals, registers the per-pin
// codes and flags, and drives each pin through its multiplexer.
// Assumes NPORT*PORT_W >= 6 so the fixed serial0 pins exist.
module pin_xbar
    import pinx_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int PORT_W = 8,
    localparam int NPIN  = NPORT * PORT_W,
    localparam int TX0_PIN = 4,
    localparam int RX0_PIN = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_uart0,
    input  logic                   en_spi,
    input  logic                   spi_4wire,
    input  logic                   en_twi,
    input  logic                   en_cmp0,
    input  logic                   en_cmp0a,
    input  logic                   en_cmp1,
    input  logic                   en_cmp1a,
    input  logic                   en_sysclk,
    input  logic [2:0]             cap_cnt,
    input  logic                   en_eci,
    input  logic                   en_t0,
    input  logic                   en_t1,
    input  logic                   en_uart1,
    input  logic [NPIN-1:0]        skip_mask,
    input  logic [NSIG-1:0]        periph_out,
    input  logic [NSIG-1:0]        periph_oe,
    input  logic [NPIN-1:0]        gpio_out,
    input  logic [NPIN-1:0]        gpio_oe,
    output logic [NPIN*CODE_W-1:0] pin_code,
    output logic [NSIG-1:0]        not_pinned,
    output logic [NPIN-1:0]        pin_out,
    output logic [NPIN-1:0]        pin_oe
);
    logic [NSIG-1:0]        req;
    logic [NPIN-1:0]        avail;
    logic [NPIN*CODE_W-1:0] packed_code;
    logic [NPIN*CODE_W-1:0] next_code;
    logic [NSIG-1:0]        unplaced;

    pinx_request u_req (
        .en_spi(en_spi), .spi_4wire(spi_4wire), .en_twi(en_twi),
        .en_cmp0(en_cmp0), .en_cmp0a(en_cmp0a), .en_cmp1(en_cmp1),
        .en_cmp1a(en_cmp1a), .en_sysclk(en_sysclk), .cap_cnt(cap_cnt),
        .en_eci(en_eci), .en_t0(en_t0), .en_t1(en_t1),
        .en_uart1(en_uart1), .req(req)
    );

    // A pin is free unless skipped or held by the fixed serial0 lines.
    always_comb begin
        for (int p = 0; p < NPIN; p++)
            avail[p] = ~skip_mask[p] & ~(en_uart0 & (p == TX0_PIN || p == RX0_PIN));
    end

    pinx_pack #(.NPIN(NPIN)) u_pack (
        .req(req), .avail(avail), .code(packed_code), .unplaced(unplaced)
    );

    // Overlay the fixed serial0 codes on the packed result.
    always_comb begin
        next_code = packed_code;
        if (en_uart0) begin
            next_code[TX0_PIN*CODE_W +: CODE_W] = C_U0TX;
            next_code[RX0_PIN*CODE_W +: CODE_W] = C_U0RX;
        end
    end

    // Capture the assignment once per clock; reset parks all pins on GPIO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_code   <= '0;
            not_pinned <= '0;
        end else begin
            pin_code   <= next_code;
            not_pinned <= unplaced;
        end
    end

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            pinx_pinmux u_mux (
                .code(pin_code[p*CODE_W +: CODE_W]),
                .periph_out(periph_out), .periph_oe(periph_oe),
                .gpio_out(gpio_out[p]), .gpio_oe(gpio_oe[p]),
                .pin_out(pin_out[p]), .pin_oe(pin_oe[p])
            );
        end
    endgenerate
endmodule

// File: rtl/pin_xbar_chk.sv
// Property checker for pin_xbar, attached through bind below.
module pin_xbar_chk
    import pinx_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   en_uart0,
    input logic                   en_spi,
    input logic                   spi_4wire,
    input logic [NPIN-1:0]        skip_mask,
    input logic [NPIN*CODE_W-1:0] pin_code,
    input logic [NSIG-1:0]        not_pinned
);
    logic [NPIN-1:0] hits [NSIG+1];

    // Per-code match vector across all pins.
    always_comb begin
        for (int c = 0; c <= NSIG; c++)
            for (int p = 0; p < NPIN; p++)
                hits[c][p] = (pin_code[p*CODE_W +: CODE_W] == CODE_W'(c));
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_code == '0 && not_pinned == '0));

    // R4
    uart0_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_uart0 |=> (pin_code[4*CODE_W +: CODE_W] == C_U0TX &&
                      pin_code[5*CODE_W +: CODE_W] == C_U0RX));

    // R9
    fixed_never_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        not_pinned[1:0] == 2'b00);

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pchk
            // R3
            skip_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (skip_mask[p] && !(en_uart0 && (p == 4 || p == 5)))
                |=> pin_code[p*CODE_W +: CODE_W] == C_GPIO);
            // R6
            nss_3wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(en_spi && spi_4wire) |=> pin_code[p*CODE_W +: CODE_W] != C_NSS);
            // R9
            flag_means_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (not_pinned != '0) |-> (pin_code[p*CODE_W +: CODE_W] != C_GPIO ||
                                        $past(skip_mask[p])));
        end
        for (genvar c = 1; c <= NSIG; c++) begin : g_cchk
            // R11
            code_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(hits[c]) <= 1);
        end
    endgenerate
endmodule

bind pin_xbar pin_xbar_chk #(.NPIN(NPIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_uart0(en_uart0), .en_spi(en_spi),
    .spi_4wire(spi_4wire), .skip_mask(skip_mask), .pin_code(pin_code),
    .not_pinned(not_pinned)
);

// File: tb/pin_xbar_test.sv
// Directed bench for pin_xbar: one task per scenario, each self-checking.
module pin_xbar_test;
    localparam int NPIN = 32;
    localparam int CW   = 5;
    localparam int NS   = 23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_uart0, en_spi, spi_4wire, en_twi, en_cmp0, en_cmp0a, en_cmp1, en_cmp1a;
    logic en_sysclk, en_eci, en_t0, en_t1, en_uart1;
    logic [2:0] cap_cnt;
    logic [NPIN-1:0] skip_mask, gpio_out, gpio_oe, pin_out, pin_oe;
    logic [NS-1:0] periph_out, periph_oe, not_pinned;
    logic [NPIN*CW-1:0] pin_code;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pin_xbar uut (
        .clk(clk), .rst_n(rst_n), .en_uart0(en_uart0), .en_spi(en_spi),
        .spi_4wire(spi_4wire), .en_twi(en_twi), .en_cmp0(en_cmp0),
        .en_cmp0a(en_cmp0a), .en_cmp1(en_cmp1), .en_cmp1a(en_cmp1a),
        .en_sysclk(en_sysclk), .cap_cnt(cap_cnt), .en_eci(en_eci),
        .en_t0(en_t0), .en_t1(en_t1), .en_uart1(en_uart1),
        .skip_mask(skip_mask), .periph_out(periph_out), .periph_oe(periph_oe),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pin_code(pin_code),
        .not_pinned(not_pinned), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_pins(input string tag, input int exp [NPIN]);
        for (int p = 0; p < NPIN; p++) begin
            n_chk++;
            if (int'(pin_code[p*CW +: CW]) != exp[p]) begin
                n_fail++;
                $display("FAIL %s pin %0d code: actual %0d expected %0d",
                         tag, p, pin_code[p*CW +: CW], exp[p]);
            end
        end
    endtask

    task automatic clear_inputs();
        {en_uart0, en_spi, spi_4wire, en_twi, en_cmp0, en_cmp0a, en_cmp1, en_cmp1a} = '0;
        {en_sysclk, en_eci, en_t0, en_t1, en_uart1} = '0;
        cap_cnt = 3'd0; skip_mask = '0; gpio_out = '0; gpio_oe = '0;
        periph_out = '0; periph_oe = '0;
    endtask

    // Inputs are set 2 ns after an edge; one register stage, so sample 2 ns after the next edge.
    task automatic settle();
        @(posedge clk); #2;
    endtask

    task automatic t_reset();
        int exp [NPIN];
        for (int p = 0; p < NPIN; p++) exp[p] = 0;
        clear_inputs(); en_spi = 1'b1; en_uart0 = 1'b1;
        rst_n = 1'b0;
        settle(); settle();
        check_pins("R1", exp);
        check("R1", "not_pinned after reset", int'(not_pinned), 0);
        rst_n = 1'b1;
        settle();
        check("R1", "pin 0 after release", int'(pin_code[0 +: CW]), 3);
    endtask

    task automatic t_example();
        int exp [NPIN];
        for (int p = 0; p < NPIN; p++) exp[p] = 0;
        clear_inputs();
        en_uart0 = 1; en_spi = 1; en_twi = 1; en_cmp0 = 1; cap_cnt = 3'd2; en_t1 = 1;
        skip_mask = 32'h0000_010C;
        settle();
        exp[0] = 3; exp[1] = 4; exp[4] = 1; exp[5] = 2; exp[6] = 5; exp[7] = 7;
        exp[9] = 8; exp[10] = 9; exp[11] = 14; exp[12] = 15; exp[13] = 21;
        check_pins("R2/R3/R4/R5/R8", exp);
        check("R9", "example not_pinned", int'(not_pinned), 0);
    endtask

    task automatic t_spi_modes();
        clear_inputs(); en_spi = 1; spi_4wire = 1;
        settle();
        check("R6", "4-wire pin 3", int'(pin_code[3*CW +: CW]), 6);
        check("R6", "4-wire pin 4 (uart0 off)", int'(pin_code[4*CW +: CW]), 0);
        spi_4wire = 0;
        settle();
        check("R6", "3-wire pin 3", int'(pin_code[3*CW +: CW]), 0);
        check("R6", "3-wire pin 2", int'(pin_code[2*CW +: CW]), 5);
    endtask

    task automatic t_capture();
        clear_inputs(); cap_cnt = 3'd7;
        settle();
        for (int i = 0; i < 5; i++)
            check("R7", "cap clamp pin", int'(pin_code[i*CW +: CW]), 14 + i);
        check("R7", "cap clamp pin 5", int'(pin_code[5*CW +: CW]), 0);
        en_uart0 = 1; cap_cnt = 3'd5;
        settle();
        check("R4", "cap skips fixed, pin 3", int'(pin_code[3*CW +: CW]), 17);
        check("R4", "cap continues at pin 6", int'(pin_code[6*CW +: CW]), 18);
        cap_cnt = 3'd0; en_uart0 = 0; en_uart1 = 1;
        settle();
        check("R5", "uart1 tx pin 0", int'(pin_code[0 +: CW]), 22);
        check("R5", "uart1 rx pin 1", int'(pin_code[1*CW +: CW]), 23);
    endtask

    task automatic t_exhaust();
        clear_inputs(); skip_mask = 32'h3FFF_FFFF; en_twi = 1; en_cmp0 = 1;
        settle();
        check("R3", "pin 29 skipped", int'(pin_code[29*CW +: CW]), 0);
        check("R2", "pin 30", int'(pin_code[30*CW +: CW]), 7);
        check("R2", "pin 31", int'(pin_code[31*CW +: CW]), 8);
        check("R9", "partial not_pinned", int'(not_pinned), 1 << 8);
        clear_inputs(); skip_mask = '1; en_uart0 = 1; en_spi = 1;
        settle();
        check("R4", "pin 4 over skip", int'(pin_code[4*CW +: CW]), 1);
        check("R4", "pin 5 over skip", int'(pin_code[5*CW +: CW]), 2);
        check("R9", "all skipped not_pinned", int'(not_pinned), 32'h1C);
    endtask

    task automatic t_mux();
        clear_inputs(); en_uart1 = 1;
        periph_out[21] = 1; periph_oe[21] = 1;
        gpio_out[2] = 1; gpio_oe[2] = 1; gpio_out[1] = 1; gpio_oe[1] = 1;
        settle();
        check("R10", "pin 0 out (tx1)", int'(pin_out[0]), 1);
        check("R10", "pin 0 oe (tx1)", int'(pin_oe[0]), 1);
        check("R10", "pin 1 out (rx1, gpio ignored)", int'(pin_out[1]), 0);
        check("R10", "pin 1 oe (rx1)", int'(pin_oe[1]), 0);
        check("R10", "pin 2 out gpio", int'(pin_out[2]), 1);
        check("R10", "pin 2 oe gpio", int'(pin_oe[2]), 1);
    endtask

    task automatic t_unique();
        int cnt;
        clear_inputs();
        en_spi = 1; spi_4wire = 1; en_twi = 1; en_cmp0 = 1; en_cmp0a = 1; en_cmp1 = 1;
        en_cmp1a = 1; en_sysclk = 1; cap_cnt = 3'd5; en_eci = 1; en_t0 = 1; en_t1 = 1;
        en_uart1 = 1; en_uart0 = 1; skip_mask = 32'h0000_00F0;
        settle();
        for (int c = 1; c <= NS; c++) begin
            cnt = 0;
            for (int p = 0; p < NPIN; p++) if (int'(pin_code[p*CW +: CW]) == c) cnt++;
            check("R11", $sformatf("code %0d occurrences", c), cnt, 1);
        end
        check("R8", "pin 31 leftover", int'(pin_code[31*CW +: CW]), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_inputs();
        #2;
        t_reset();
        t_example();
        t_spi_modes();
        t_capture();
        t_exhaust();
        t_mux();
        t_unique();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule